// File: doc/BRIEF.md
# SDRAM Double Auto-Refresh Sequencer

This block keeps a synchronous DRAM refreshed without help from software. A refresh timer is clocked through a selectable prescaler. When the timer reaches a programmable compare value it clears itself and raises a pending request. The sequencer answers each request with a pair of auto-refresh commands. It enforces two separately programmed recovery gaps: one between the two commands, and one after the second. Only after both gaps does it hand the bus back, so the access path can open a row again.

The block works with the access arbiter through a simple handshake. It raises `ref_busy` and waits for `arb_grant`, which the arbiter gives once every bank is precharged and idle. It then drives the command pins. In every cycle where it does not issue a refresh, it drives a no-operation. The clock enable stays high throughout.

The controller has six states. SQ_IDLE moves to SQ_WAIT_GNT when a request is pending. SQ_WAIT_GNT moves to SQ_REF1 when the grant is seen. SQ_REF1 always moves to SQ_GAP1. SQ_GAP1 moves to SQ_REF2 when the gap counter expires. SQ_REF2 always moves to SQ_GAP2. When the gap counter expires in SQ_GAP2, the controller goes to SQ_WAIT_GNT if another request is pending, and otherwise to SQ_IDLE. Busy is high in every state except SQ_IDLE.

Top module: `sdram_dual_refresh`

## Requirements
- R1: While reset is held, `ref_busy` is 0, the command pins carry a no-operation and `sd_cke` is 1.
- R2: Each refresh request yields exactly two refresh commands. A refresh command is CS, RAS and CAS low with WE high for one cycle. Every other cycle is a no-operation: CS low with RAS, CAS and WE high.
- R3: The second refresh command comes exactly `cfg_ref_gap + 4` cycles after the first, which gives 4 to 11 cycles.
- R4: `ref_busy` falls exactly `(cfg_ref_gap + 4) + 3*cfg_rec_ext` cycles after the second refresh command, which gives 4 to 32 cycles. No earlier fall is possible.
- R5: Requests recur every `(cfg_compare + 1) * 4^cfg_prescale` clock cycles. A request stays pending until the first refresh command of its sequence. The first refresh commands of consecutive sequences are therefore spaced by that period.
- R6: `ref_busy` rises before any refresh command. No refresh command is issued unless `arb_grant` was high at the edge before it, and no refresh command appears in the first busy cycle.
- R7: A request that arrives during a sequence is kept. With the grant held, `ref_busy` then stays high, and the next first refresh command follows the previous second one by exactly the post-refresh gap plus one cycle.
- R8: `sd_cke` is 1 in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_prescale | input | 3 | Timer clock divide select, divide by 4^value |
| cfg_compare | input | CMP_W | Timer compare value |
| cfg_ref_gap | input | 3 | Gap between the two refresh commands, value + 4 cycles |
| cfg_rec_ext | input | 3 | Post-refresh extension, 3 cycles per step |
| arb_grant | input | 1 | Arbiter grant: banks precharged and bus free |
| ref_busy | output | 1 | Refresh sequence owns the bus |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_cke | output | 1 | Clock enable |

## Verification
The bench builds the block with an 8-bit compare value and keeps the default divide step of 2, so all eight prescaler settings finish within the run, the slowest at 16384 cycles per request. The two 3-bit gap fields are small enough to sweep all 64 combinations, each checked against the arithmetic spacing. Short compare values bring back-to-back requests within reach. A held-off grant exercises the waiting state.

// File: rtl/sdrr_pkg.sv
package sdrr_pkg;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_WAIT_GNT,
        SQ_REF1,
        SQ_GAP1,
        SQ_REF2,
        SQ_GAP2
    } sq_state_t;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } sd_cmd_t;

    localparam sd_cmd_t CMD_NOP = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
    localparam sd_cmd_t CMD_REF = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};

    // cycles from one refresh command to the next
    function automatic int ref_spacing(input int field, input int base);
        return base + field;
    endfunction

    // cycles from the second refresh command to release of the bus
    function automatic int rec_spacing(input int gap_field, input int ext_field,
                                       input int base, input int step);
        return base + gap_field + step * ext_field;
    endfunction

endpackage

// File: rtl/sdrr_prescaler.sv
module sdrr_prescaler #(
    parameter int SEL_W    = 3,
    parameter int DIV_STEP = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);

    localparam int PRE_W = (DIV_STEP * ((1 << SEL_W) - 1) > 0) ?
                           DIV_STEP * ((1 << SEL_W) - 1) : 1;

    generate
        if (DIV_STEP == 0) begin : g_nodiv
            assign tick = 1'b1;
        end else begin : g_div
            logic [PRE_W-1:0] cnt;
            logic [PRE_W-1:0] limit;

            // limit = 2^(DIV_STEP*sel) - 1
            always_comb limit = ~({PRE_W{1'b1}} << (int'(sel) * DIV_STEP));

            assign tick = (cnt >= limit);

            always_ff @(posedge clk) begin
                if (!rst_n)
                    cnt <= '0;
                else if (tick)
                    cnt <= '0;
                else
                    cnt <= cnt + 1'b1;
            end
        end
    endgenerate

endmodule

// File: rtl/sdrr_interval_timer.sv
module sdrr_interval_timer #(
    parameter int CMP_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [CMP_W-1:0] cmp,
    output logic             hit
);

    logic [CMP_W-1:0] cnt;

    assign hit = tick && (cnt >= cmp);

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (hit)
            cnt <= '0;
        else if (tick)
            cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/sdrr_gap_counter.sv
module sdrr_gap_counter #(
    parameter int GAP_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [GAP_W-1:0] load_val,
    output logic             done
);

    logic [GAP_W-1:0] cnt;

    assign done = (cnt == '0);

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (!done)
            cnt <= cnt - 1'b1;
    end

endmodule

// File: rtl/sdram_dual_refresh.sv
module sdram_dual_refresh
    import sdrr_pkg::*;
#(
    parameter int CMP_W    = 12,
    parameter int FIELD_W  = 3,
    parameter int DIV_STEP = 2,
    parameter int GAP_BASE = 4,
    parameter int EXT_STEP = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [2:0]         cfg_prescale,
    input  logic [CMP_W-1:0]   cfg_compare,
    input  logic [FIELD_W-1:0] cfg_ref_gap,
    input  logic [FIELD_W-1:0] cfg_rec_ext,
    input  logic               arb_grant,
    output logic               ref_busy,
    output logic               sd_cs_n,
    output logic               sd_ras_n,
    output logic               sd_cas_n,
    output logic               sd_we_n,
    output logic               sd_cke
);

    localparam int FIELD_MAX = (1 << FIELD_W) - 1;
    localparam int GAP_MAX   = GAP_BASE + FIELD_MAX * (1 + EXT_STEP);
    localparam int GAP_W     = $clog2(GAP_MAX + 1);

    sq_state_t        state;
    sq_state_t        state_nx;
    logic             tick;
    logic             hit;
    logic             pend;
    logic             gap_load;
    logic [GAP_W-1:0] gap_val;
    logic             gap_done;
    sd_cmd_t          cmd;
    logic             busy_c;

    sdrr_prescaler #(
        .SEL_W    (3),
        .DIV_STEP (DIV_STEP)
    ) u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .sel   (cfg_prescale),
        .tick  (tick)
    );

    sdrr_interval_timer #(
        .CMP_W (CMP_W)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .cmp   (cfg_compare),
        .hit   (hit)
    );

    sdrr_gap_counter #(
        .GAP_W (GAP_W)
    ) u_gap (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (gap_load),
        .load_val (gap_val),
        .done     (gap_done)
    );

    // pending request: a new hit wins over the clear from the first refresh
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend <= 1'b0;
        else
            pend <= hit | (pend & (state != SQ_REF1));
    end

    // gap counter load: the refresh cycle itself and the exit cycle are not counted
    always_comb begin
        gap_load = 1'b0;
        gap_val  = '0;
        if (state == SQ_REF1) begin
            gap_load = 1'b1;
            gap_val  = GAP_W'(ref_spacing(int'(cfg_ref_gap), GAP_BASE) - 2);
        end else if (state == SQ_REF2) begin
            gap_load = 1'b1;
            gap_val  = GAP_W'(rec_spacing(int'(cfg_ref_gap), int'(cfg_rec_ext),
                                          GAP_BASE, EXT_STEP) - 2);
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            SQ_IDLE:     if (pend)      state_nx = SQ_WAIT_GNT;
            SQ_WAIT_GNT: if (arb_grant) state_nx = SQ_REF1;
            SQ_REF1:                    state_nx = SQ_GAP1;
            SQ_GAP1:     if (gap_done)  state_nx = SQ_REF2;
            SQ_REF2:                    state_nx = SQ_GAP2;
            SQ_GAP2:     if (gap_done)  state_nx = pend ? SQ_WAIT_GNT : SQ_IDLE;
            default:                    state_nx = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= SQ_IDLE;
        else
            state <= state_nx;
    end

    always_comb begin
        cmd    = CMD_NOP;
        busy_c = 1'b1;
        unique case (state)
            SQ_IDLE:     busy_c = 1'b0;
            SQ_WAIT_GNT: cmd    = CMD_NOP;
            SQ_REF1:     cmd    = CMD_REF;
            SQ_GAP1:     cmd    = CMD_NOP;
            SQ_REF2:     cmd    = CMD_REF;
            SQ_GAP2:     cmd    = CMD_NOP;
            default:     busy_c = 1'b0;
        endcase
    end

    assign ref_busy = busy_c;
    assign sd_cs_n  = cmd.cs_n;
    assign sd_ras_n = cmd.ras_n;
    assign sd_cas_n = cmd.cas_n;
    assign sd_we_n  = cmd.we_n;
    assign sd_cke   = 1'b1;

endmodule

// File: rtl/sdram_dual_refresh_chk.sv
module sdram_dual_refresh_chk (
    input logic clk,
    input logic rst_n,
    input logic ref_busy,
    input logic sd_cs_n,
    input logic sd_ras_n,
    input logic sd_cas_n,
    input logic sd_we_n,
    input logic sd_cke
);

    logic       is_ref;
    logic       is_nop;
    logic [3:0] since_ref;
    logic       seen_ref;

    assign is_ref = !sd_cs_n && !sd_ras_n && !sd_cas_n && sd_we_n;
    assign is_nop = !sd_cs_n && sd_ras_n && sd_cas_n && sd_we_n;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_ref <= '0;
            seen_ref  <= 1'b0;
        end else if (is_ref) begin
            since_ref <= 4'd1;
            seen_ref  <= 1'b1;
        end else if (since_ref != 4'd15) begin
            since_ref <= since_ref + 4'd1;
        end
    end

    // R2
    cmd_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_ref || is_nop);

    // R3
    ref_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_ref && seen_ref) |-> (since_ref >= 4'd4));

    // R3
    no_adjacent_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_ref |=> !is_ref);

    // R4
    release_after_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ref_busy) |-> $past(is_nop));

    // R6
    ref_under_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_ref |-> ref_busy);

    // R6
    busy_first_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ref_busy) |-> !is_ref);

    // R8
    cke_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sd_cke);

endmodule

bind sdram_dual_refresh sdram_dual_refresh_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ref_busy (ref_busy),
    .sd_cs_n  (sd_cs_n),
    .sd_ras_n (sd_ras_n),
    .sd_cas_n (sd_cas_n),
    .sd_we_n  (sd_we_n),
    .sd_cke   (sd_cke)
);

// File: tb/sdram_dual_refresh_tb.sv
module sdram_dual_refresh_tb;

    localparam int CMP_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [2:0]       sel = '0;
    logic [CMP_W-1:0] cmpv = '0;
    logic [2:0]       gap = '0;
    logic [2:0]       ext = '0;
    logic             grant = 1'b0;
    logic             busy, cs_n, ras_n, cas_n, we_n, cke;

    always #5 clk = ~clk;

    sdram_dual_refresh #(.CMP_W(CMP_W)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_prescale (sel),
        .cfg_compare  (cmpv),
        .cfg_ref_gap  (gap),
        .cfg_rec_ext  (ext),
        .arb_grant    (grant),
        .ref_busy     (busy),
        .sd_cs_n      (cs_n),
        .sd_ras_n     (ras_n),
        .sd_cas_n     (cas_n),
        .sd_we_n      (we_n),
        .sd_cke       (cke)
    );

    int checks = 0;
    int fails  = 0;
    int total_cyc = 0;
    int cyc, t1, t2, seqs, busy_run;
    int gdelay = 0;
    int exp_period = 0;
    bit btb = 0;
    bit have_t1, have_t2, second, prev_busy;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int n1();
        return int'(gap) + 4;
    endfunction

    function automatic int pgap();
        return int'(gap) + 4 + 3 * int'(ext);
    endfunction

    // monitor, sampling away from the active edge
    always @(negedge clk) begin
        bit is_ref, is_nop;
        total_cyc++;
        is_ref = !cs_n && !ras_n && !cas_n && we_n;
        is_nop = !cs_n && ras_n && cas_n && we_n;
        if (!rst_n) begin
            cyc = 0; have_t1 = 0; have_t2 = 0; second = 0;
            prev_busy = 0; busy_run = 0; seqs = 0; grant = 0;
        end else begin
            cyc++;
            // R8
            chk(cke == 1'b1, "R8", int'(cke), 1);
            // R2 command legality
            chk(is_ref || is_nop, "R2", {28'd0, cs_n, ras_n, cas_n, we_n}, 4'b0111);
            if (is_ref) begin
                // R6
                chk(busy == 1'b1, "R6", int'(busy), 1);
                chk(grant == 1'b1, "R6", int'(grant), 1);
                if (!second) begin
                    if (have_t1 && exp_period != 0)
                        chk(cyc - t1 == exp_period, "R5", cyc - t1, exp_period);
                    if (have_t2 && btb)
                        chk(cyc - t2 == pgap() + 1, "R7", cyc - t2, pgap() + 1);
                    t1 = cyc; have_t1 = 1; second = 1;
                end else begin
                    // R3
                    chk(cyc - t1 == n1(), "R3", cyc - t1, n1());
                    t2 = cyc; have_t2 = 1; second = 0; seqs++;
                end
            end
            if (prev_busy && !busy) begin
                // R4
                chk(!second && have_t2 && (cyc - t2 == pgap()), "R4", cyc - t2, pgap());
                if (btb) chk(1'b0, "R7", 0, 1);
            end
            prev_busy = busy;
            busy_run  = busy ? busy_run + 1 : 0;
            grant     = busy && (busy_run > gdelay);
        end
    end

    task automatic run_cfg(input int s, input int c, input int g, input int e,
                           input int gd, input int per, input bit b, input int nseq);
        int guard;
        rst_n = 1'b0;
        sel = 3'(s); cmpv = CMP_W'(c); gap = 3'(g); ext = 3'(e);
        gdelay = gd; exp_period = per; btb = b;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(busy == 1'b0, "R1", int'(busy), 0);
        chk(!cs_n && ras_n && cas_n && we_n, "R1", {28'd0, cs_n, ras_n, cas_n, we_n}, 4'b0111);
        chk(cke == 1'b1, "R1", int'(cke), 1);
        rst_n = 1'b1;
        @(negedge clk);
        guard = 0;
        while (seqs < nseq && guard < 40000) begin
            @(negedge clk);
            guard++;
        end
        // R2 every request produced its pair of refresh commands
        chk(seqs >= nseq, "R2", seqs, nseq);
        if (!b) begin
            guard = 0;
            while (busy && guard < 100) begin
                @(negedge clk);
                guard++;
            end
            @(negedge clk);
        end
    endtask

    initial begin
        // R3 R4 R5: full sweep of both gap fields
        for (int g = 0; g < 8; g++)
            for (int e = 0; e < 8; e++)
                run_cfg(0, 63, g, e, (g + e) % 4, 64, 1'b0, 2);
        // R5: every prescaler step
        for (int s = 0; s < 8; s++) begin
            int c;
            c = (s == 0) ? 63 : (s == 1) ? 15 : (s == 2) ? 3 : 0;
            run_cfg(s, c, 2, 1, 1, (c + 1) << (2 * s), 1'b0, 2);
        end
        // R6: grant held off for a long time
        run_cfg(0, 99, 5, 3, 25, 100, 1'b0, 2);
        // R7: requests arrive faster than sequences finish
        run_cfg(0, 29, 7, 7, 0, 0, 1'b1, 5);
        run_cfg(0, 9, 3, 5, 0, 0, 1'b1, 4);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        wait (total_cyc >= 190000);
        fails++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", total_cyc, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule